// File: doc/BRIEF.md
# Merged Register File Renamer

This block maps architectural destination registers onto one shared pool of physical registers. A group of up to three micro-operations arrives each cycle. Each valid slot gets the physical names of its two sources, a fresh physical register for its destination, the physical register that destination held before, and a reorder buffer index. All of these come back in the same cycle as combinational outputs. The group is taken at the clock edge only when the pool and the reorder buffer both have room for the whole group.

Two alias tables are kept. The front-end table follows speculative renaming. The retirement table follows committed state. The reorder buffer stores only status: the architectural destination, the new physical register and the previous one. Register values live elsewhere and never move. Retiring an entry writes its new mapping into the retirement table and sends its previous physical register to the tail of a circular free list. A flush copies the retirement table into the front-end table. It also winds the free-list head back to a pointer that advances only on retirement, and empties the reorder buffer.

Top module: `mrf_renamer`

## Requirements
- R1: After reset both alias tables map architectural register i to physical register i. The free list holds physical registers 8 to 127 in ascending order, and the reorder buffer is empty.
- R2: The valid slots of a group take consecutive free-list entries from the head, in ascending slot order, skipping invalid slots. The register a slot takes is shown on `dst_phys_o`.
- R3: A source maps to the physical register given by the front-end table, unless an earlier valid slot in the same group writes that architectural register. In that case the source takes the latest such slot's new register.
- R4: `old_phys_o` gives the destination's prior mapping, and the same-group rule of R3 applies to it.
- R5: Reorder buffer indices are handed out sequentially modulo 32. A valid slot's index is the tail plus the number of valid slots below it.
- R6: `alloc_rdy_o` is high exactly when the number of valid slots is no more than the free physical registers and no more than the free reorder buffer slots (32 minus the occupancy). A group that is not ready changes no state.
- R7: `ret_vld_o` has its lowest min(`ret_req_i`, occupancy) bits set. Those entries are the oldest, oldest in bit 0, and they leave the reorder buffer at the edge.
- R8: Each retiring entry shows its previous physical register on `ret_free_o`. That register is appended to the free list in slot order, and the entry's new mapping is written into the retirement table.
- R9: While `flush_i` is high, allocation and retirement are ignored and `ret_vld_o` is zero. At the edge the front-end table takes the retirement table and the free-list head returns to the retirement pointer. The reorder buffer becomes empty.
- R10: Retirement never changes the front-end table, so source lookups are unaffected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Restore speculative state from retirement state |
| alloc_vld_i | input | 3 | Valid bit per group slot |
| alloc_dst_i | input | 3x3 | Architectural destination per slot |
| alloc_src1_i | input | 3x3 | First architectural source per slot |
| alloc_src2_i | input | 3x3 | Second architectural source per slot |
| alloc_rdy_o | output | 1 | Group fits in free resources |
| dst_phys_o | output | 3x7 | New physical destination per slot |
| old_phys_o | output | 3x7 | Prior mapping of the destination per slot |
| src1_phys_o | output | 3x7 | Physical first source per slot |
| src2_phys_o | output | 3x7 | Physical second source per slot |
| rob_idx_o | output | 3x5 | Reorder buffer index per slot |
| ret_req_i | input | 2 | Number of oldest entries to retire (0 to 3) |
| ret_vld_o | output | 3 | Retiring slot mask, oldest in bit 0 |
| ret_free_o | output | 3x7 | Physical register freed per retiring slot |

## Verification
The checker assumes that `flush_i` is held low for the cycles before the first edge after reset. It also assumes that retirement requests stay within 0 to 3; occupancy clamping keeps them safe beyond that. Group-wise properties such as distinct destinations and sequential indices are checked only when the group is ready. Those values are undefined for a group that will stall. The stimulus drives random valid masks, architectural numbers, retirement counts and rare flushes, all inside these ranges. A reference model advances only when the requirement rules say so, and it is checked against the outputs every cycle. Directed sequences fill the reorder buffer to its limit, test same-group bypass, and check flush recovery.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  localparam int unsigned ARCH_N_DEF = 8;
  localparam int unsigned PHYS_N_DEF = 128;
  localparam int unsigned ROB_N_DEF  = 32;
  localparam int unsigned GRP_W_DEF  = 3;
endpackage

// File: rtl/mrf_free_list.sv
module mrf_free_list #(
  parameter int unsigned PHYS_N = 128,
  parameter int unsigned ARCH_N = 8,
  parameter int unsigned GRP_W  = 3,
  parameter int unsigned PW     = $clog2(PHYS_N),
  parameter int unsigned CW     = $clog2(GRP_W + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [CW-1:0]             pop_n_i,
  input  logic [CW-1:0]             push_n_i,
  input  logic [GRP_W-1:0][PW-1:0]  push_ids_i,
  output logic [GRP_W-1:0][PW-1:0]  head_ids_o,
  output logic [PW:0]               free_cnt_o
);
  logic [PW-1:0] mem_q [PHYS_N];
  logic [PW:0]   head_q, tail_q, ret_q;

  assign free_cnt_o = tail_q - head_q;

  for (genvar k = 0; k < GRP_W; k++) begin : g_head
    assign head_ids_o[k] = mem_q[head_q[PW-1:0] + PW'(k)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS_N; i++)
        mem_q[i] <= (i < PHYS_N - ARCH_N) ? PW'(ARCH_N + i) : '0;
      head_q <= '0;
      tail_q <= (PW+1)'(PHYS_N - ARCH_N);
      ret_q  <= '0;
    end else begin
      for (int k = 0; k < GRP_W; k++)
        if (CW'(k) < push_n_i) mem_q[tail_q[PW-1:0] + PW'(k)] <= push_ids_i[k];
      tail_q <= tail_q + (PW+1)'(push_n_i);
      // retired entries consumed their free-list slots in allocation order
      ret_q  <= ret_q + (PW+1)'(push_n_i);
      if (flush_i) head_q <= ret_q;
      else         head_q <= head_q + (PW+1)'(pop_n_i);
    end
  end
endmodule

// File: rtl/mrf_rob.sv
module mrf_rob #(
  parameter int unsigned ROB_N = 32,
  parameter int unsigned GRP_W = 3,
  parameter int unsigned AW    = 3,
  parameter int unsigned PW    = 7,
  parameter int unsigned RW    = $clog2(ROB_N),
  parameter int unsigned CW    = $clog2(GRP_W + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [GRP_W-1:0]          we_i,
  input  logic [GRP_W-1:0][CW-1:0]  off_i,
  input  logic [GRP_W-1:0][AW-1:0]  arch_i,
  input  logic [GRP_W-1:0][PW-1:0]  new_i,
  input  logic [GRP_W-1:0][PW-1:0]  old_i,
  input  logic [CW-1:0]             alloc_n_i,
  input  logic [CW-1:0]             ret_req_i,
  output logic [RW-1:0]             tail_o,
  output logic [RW:0]               occ_o,
  output logic [CW-1:0]             ret_n_o,
  output logic [GRP_W-1:0]          ret_vld_o,
  output logic [GRP_W-1:0][AW-1:0]  ret_arch_o,
  output logic [GRP_W-1:0][PW-1:0]  ret_new_o,
  output logic [GRP_W-1:0][PW-1:0]  ret_old_o
);
  logic [AW-1:0] arch_q [ROB_N];
  logic [PW-1:0] new_q  [ROB_N];
  logic [PW-1:0] old_q  [ROB_N];
  logic [RW:0]   head_q, tail_q;

  assign occ_o   = tail_q - head_q;
  assign tail_o  = tail_q[RW-1:0];
  assign ret_n_o = ((RW+1)'(ret_req_i) > occ_o) ? CW'(occ_o) : ret_req_i;

  for (genvar k = 0; k < GRP_W; k++) begin : g_ret
    logic [RW-1:0] idx;
    assign idx           = head_q[RW-1:0] + RW'(k);
    assign ret_vld_o[k]  = CW'(k) < ret_n_o;
    assign ret_arch_o[k] = arch_q[idx];
    assign ret_new_o[k]  = new_q[idx];
    assign ret_old_o[k]  = old_q[idx];
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < GRP_W; k++)
      if (we_i[k]) begin
        arch_q[tail_q[RW-1:0] + RW'(off_i[k])] <= arch_i[k];
        new_q[tail_q[RW-1:0] + RW'(off_i[k])]  <= new_i[k];
        old_q[tail_q[RW-1:0] + RW'(off_i[k])]  <= old_i[k];
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + (RW+1)'(ret_n_o);
      if (flush_i) tail_q <= head_q;
      else         tail_q <= tail_q + (RW+1)'(alloc_n_i);
    end
  end
endmodule

// File: rtl/mrf_alias.sv
module mrf_alias #(
  parameter int unsigned ARCH_N = 8,
  parameter int unsigned GRP_W  = 3,
  parameter int unsigned AW     = 3,
  parameter int unsigned PW     = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      upd_i,
  input  logic [GRP_W-1:0]          vld_i,
  input  logic [GRP_W-1:0][AW-1:0]  dst_i,
  input  logic [GRP_W-1:0][AW-1:0]  src1_i,
  input  logic [GRP_W-1:0][AW-1:0]  src2_i,
  input  logic [GRP_W-1:0][PW-1:0]  new_i,
  output logic [GRP_W-1:0][PW-1:0]  src1_o,
  output logic [GRP_W-1:0][PW-1:0]  src2_o,
  output logic [GRP_W-1:0][PW-1:0]  old_o,
  input  logic [GRP_W-1:0]          ret_vld_i,
  input  logic [GRP_W-1:0][AW-1:0]  ret_arch_i,
  input  logic [GRP_W-1:0][PW-1:0]  ret_new_i
);
  logic [PW-1:0] frat_q [ARCH_N];
  logic [PW-1:0] rrat_q [ARCH_N];

  // lookup with bypass from older slots of the same group
  always_comb begin
    for (int k = 0; k < GRP_W; k++) begin
      src1_o[k] = frat_q[src1_i[k]];
      src2_o[k] = frat_q[src2_i[k]];
      old_o[k]  = frat_q[dst_i[k]];
      for (int j = 0; j < k; j++) begin
        if (vld_i[j] && dst_i[j] == src1_i[k]) src1_o[k] = new_i[j];
        if (vld_i[j] && dst_i[j] == src2_i[k]) src2_o[k] = new_i[j];
        if (vld_i[j] && dst_i[j] == dst_i[k])  old_o[k]  = new_i[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_N; i++) begin
        frat_q[i] <= PW'(i);
        rrat_q[i] <= PW'(i);
      end
    end else begin
      if (flush_i) begin
        for (int i = 0; i < ARCH_N; i++) frat_q[i] <= rrat_q[i];
      end else if (upd_i) begin
        for (int k = 0; k < GRP_W; k++)
          if (vld_i[k]) frat_q[dst_i[k]] <= new_i[k];
      end
      for (int k = 0; k < GRP_W; k++)
        if (ret_vld_i[k]) rrat_q[ret_arch_i[k]] <= ret_new_i[k];
    end
  end
endmodule

// File: rtl/mrf_renamer.sv
module mrf_renamer #(
  parameter int unsigned ARCH_N = mrf_pkg::ARCH_N_DEF,
  parameter int unsigned PHYS_N = mrf_pkg::PHYS_N_DEF,
  parameter int unsigned ROB_N  = mrf_pkg::ROB_N_DEF,
  parameter int unsigned GRP_W  = mrf_pkg::GRP_W_DEF,
  parameter int unsigned AW     = $clog2(ARCH_N),
  parameter int unsigned PW     = $clog2(PHYS_N),
  parameter int unsigned RW     = $clog2(ROB_N),
  parameter int unsigned CW     = $clog2(GRP_W + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [GRP_W-1:0]          alloc_vld_i,
  input  logic [GRP_W-1:0][AW-1:0]  alloc_dst_i,
  input  logic [GRP_W-1:0][AW-1:0]  alloc_src1_i,
  input  logic [GRP_W-1:0][AW-1:0]  alloc_src2_i,
  output logic                      alloc_rdy_o,
  output logic [GRP_W-1:0][PW-1:0]  dst_phys_o,
  output logic [GRP_W-1:0][PW-1:0]  old_phys_o,
  output logic [GRP_W-1:0][PW-1:0]  src1_phys_o,
  output logic [GRP_W-1:0][PW-1:0]  src2_phys_o,
  output logic [GRP_W-1:0][RW-1:0]  rob_idx_o,
  input  logic [CW-1:0]             ret_req_i,
  output logic [GRP_W-1:0]          ret_vld_o,
  output logic [GRP_W-1:0][PW-1:0]  ret_free_o
);
  logic [GRP_W-1:0][CW-1:0] off;
  logic [CW-1:0]            req_n, ret_n, ret_req;
  logic [PW:0]              free_cnt;
  logic [RW:0]              rob_occ;
  logic [RW-1:0]            rob_tail;
  logic                     fire;
  logic [GRP_W-1:0][PW-1:0] head_ids;
  logic [GRP_W-1:0][AW-1:0] ret_arch;
  logic [GRP_W-1:0][PW-1:0] ret_new;

  always_comb begin
    req_n = '0;
    for (int k = 0; k < GRP_W; k++) begin
      off[k] = req_n;
      req_n  = req_n + CW'(alloc_vld_i[k]);
    end
  end

  assign alloc_rdy_o = ((PW+1)'(req_n) <= free_cnt) &&
                       ((RW+1)'(req_n) <= (RW+1)'(ROB_N) - rob_occ);
  assign fire    = alloc_rdy_o && (|alloc_vld_i) && !flush_i;
  assign ret_req = flush_i ? '0 : ret_req_i;

  for (genvar k = 0; k < GRP_W; k++) begin : g_slot
    assign dst_phys_o[k] = head_ids[off[k]];
    assign rob_idx_o[k]  = rob_tail + RW'(off[k]);
  end

  mrf_free_list #(.PHYS_N(PHYS_N), .ARCH_N(ARCH_N), .GRP_W(GRP_W), .PW(PW), .CW(CW)) u_fl (
    .clk_i, .rst_ni, .flush_i,
    .pop_n_i    (fire ? req_n : '0),
    .push_n_i   (ret_n),
    .push_ids_i (ret_free_o),
    .head_ids_o (head_ids),
    .free_cnt_o (free_cnt)
  );

  mrf_rob #(.ROB_N(ROB_N), .GRP_W(GRP_W), .AW(AW), .PW(PW), .RW(RW), .CW(CW)) u_rob (
    .clk_i, .rst_ni, .flush_i,
    .we_i       (alloc_vld_i & {GRP_W{fire}}),
    .off_i      (off),
    .arch_i     (alloc_dst_i),
    .new_i      (dst_phys_o),
    .old_i      (old_phys_o),
    .alloc_n_i  (fire ? req_n : '0),
    .ret_req_i  (ret_req),
    .tail_o     (rob_tail),
    .occ_o      (rob_occ),
    .ret_n_o    (ret_n),
    .ret_vld_o  (ret_vld_o),
    .ret_arch_o (ret_arch),
    .ret_new_o  (ret_new),
    .ret_old_o  (ret_free_o)
  );

  mrf_alias #(.ARCH_N(ARCH_N), .GRP_W(GRP_W), .AW(AW), .PW(PW)) u_alias (
    .clk_i, .rst_ni, .flush_i,
    .upd_i      (fire),
    .vld_i      (alloc_vld_i),
    .dst_i      (alloc_dst_i),
    .src1_i     (alloc_src1_i),
    .src2_i     (alloc_src2_i),
    .new_i      (dst_phys_o),
    .src1_o     (src1_phys_o),
    .src2_o     (src2_phys_o),
    .old_o      (old_phys_o),
    .ret_vld_i  (ret_vld_o),
    .ret_arch_i (ret_arch),
    .ret_new_i  (ret_new)
  );
endmodule

// File: rtl/mrf_renamer_chk.sv
module mrf_renamer_chk #(
  parameter int unsigned GRP_W = 3,
  parameter int unsigned AW    = 3,
  parameter int unsigned PW    = 7,
  parameter int unsigned RW    = 5
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      flush_i,
  input logic [GRP_W-1:0]          alloc_vld_i,
  input logic [GRP_W-1:0][AW-1:0]  alloc_dst_i,
  input logic                      alloc_rdy_o,
  input logic [GRP_W-1:0][PW-1:0]  dst_phys_o,
  input logic [GRP_W-1:0][PW-1:0]  old_phys_o,
  input logic [GRP_W-1:0][RW-1:0]  rob_idx_o,
  input logic [GRP_W-1:0]          ret_vld_o,
  input logic [GRP_W-1:0][PW-1:0]  ret_free_o
);
  // R2
  dst_uniq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_vld_i[0] && alloc_vld_i[1] && alloc_rdy_o) |-> dst_phys_o[0] != dst_phys_o[1]);
  // R4
  old_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_vld_i[0] && alloc_vld_i[1] && alloc_dst_i[0] == alloc_dst_i[1])
      |-> old_phys_o[1] == dst_phys_o[0]);
  // R5
  rob_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_vld_i[0] && alloc_vld_i[1]) |-> rob_idx_o[1] == RW'(rob_idx_o[0] + 1'b1));
  // R6
  rdy_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_vld_i == '0) |-> alloc_rdy_o);
  // R7
  ret_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GRP_W'(ret_vld_o + 1'b1) & ret_vld_o) == '0);
  // R8
  ret_uniq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_vld_o[0] && ret_vld_o[1]) |-> ret_free_o[0] != ret_free_o[1]);
  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ret_vld_o == '0);
endmodule

bind mrf_renamer mrf_renamer_chk #(.GRP_W(GRP_W), .AW(AW), .PW(PW), .RW(RW)) u_chk (.*);

// File: tb/tb_mrf_renamer.sv
module tb_mrf_renamer;
  logic clk = 1'b0, rst_ni = 1'b0, flush;
  logic [2:0] vld, rvld, rdy;
  logic [2:0][2:0] dst, s1, s2;
  logic [1:0] req;
  logic [2:0][6:0] dphys, ophys, p1, p2, rfree;
  logic [2:0][4:0] ridx;
  int n_chk = 0, n_err = 0;
  int m_frat[8], m_rrat[8], m_fl[128];
  int m_arch[32], m_new[32], m_old[32];
  int m_fh, m_ft, m_fr, m_rh, m_rt;
  bit first, post_flush, post_ret;

  always #5 clk = ~clk;

  mrf_renamer dut (
    .clk_i(clk), .rst_ni, .flush_i(flush), .alloc_vld_i(vld), .alloc_dst_i(dst),
    .alloc_src1_i(s1), .alloc_src2_i(s2), .alloc_rdy_o(rdy[0]), .dst_phys_o(dphys),
    .old_phys_o(ophys), .src1_phys_o(p1), .src2_phys_o(p2), .rob_idx_o(ridx),
    .ret_req_i(req), .ret_vld_o(rvld), .ret_free_o(rfree));
  assign rdy[2:1] = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] v, input logic [2:0][2:0] d, input logic [2:0][2:0] a,
                      input logic [2:0][2:0] b, input int r, input bit f);
    int tmp[8];
    int cnt, occ, free, off, rn, e_new;
    bit e_rdy;
    string st;
    @(negedge clk);
    vld = v; dst = d; s1 = a; s2 = b; req = 2'(r); flush = f;
    #1;
    cnt = 0;
    for (int k = 0; k < 3; k++) cnt += int'(v[k]);
    occ = m_rt - m_rh; free = m_ft - m_fh;
    e_rdy = (cnt <= free) && (cnt <= 32 - occ);
    chk(rdy[0] == e_rdy, "R6 ready", int'(rdy[0]), int'(e_rdy));
    st = first ? "R1 src" : post_flush ? "R9 src" : post_ret ? "R10 src" : "R3 src";
    for (int i = 0; i < 8; i++) tmp[i] = m_frat[i];
    off = 0;
    for (int k = 0; k < 3; k++) if (v[k]) begin
      e_new = m_fl[(m_fh + off) % 128];
      if (e_rdy) chk(int'(dphys[k]) == e_new, first ? "R1 dst" : "R2 dst", int'(dphys[k]), e_new);
      chk(int'(p1[k]) == tmp[a[k]], st, int'(p1[k]), tmp[a[k]]);
      chk(int'(p2[k]) == tmp[b[k]], st, int'(p2[k]), tmp[b[k]]);
      chk(int'(ophys[k]) == tmp[d[k]], "R4 old", int'(ophys[k]), tmp[d[k]]);
      chk(int'(ridx[k]) == (m_rt + off) % 32, "R5 rob idx", int'(ridx[k]), (m_rt + off) % 32);
      tmp[d[k]] = e_new;
      off++;
    end
    rn = f ? 0 : (r < occ ? r : occ);
    for (int k = 0; k < 3; k++) begin
      chk(rvld[k] == (k < rn), f ? "R9 ret_vld" : "R7 ret_vld", int'(rvld[k]), int'(k < rn));
      if (k < rn) chk(int'(rfree[k]) == m_old[(m_rh + k) % 32], "R8 freed",
                      int'(rfree[k]), m_old[(m_rh + k) % 32]);
    end
    @(posedge clk);
    first = 0; post_flush = f; post_ret = (rn > 0);
    if (f) begin
      for (int i = 0; i < 8; i++) m_frat[i] = m_rrat[i];
      m_fh = m_fr; m_rt = m_rh;
    end else begin
      for (int k = 0; k < rn; k++) begin
        m_rrat[m_arch[(m_rh + k) % 32]] = m_new[(m_rh + k) % 32];
        m_fl[m_ft % 128] = m_old[(m_rh + k) % 32];
        m_ft++; m_fr++;
      end
      m_rh += rn;
      if (e_rdy) for (int k = 0; k < 3; k++) if (v[k]) begin
        m_arch[m_rt % 32] = int'(d[k]);
        m_new[m_rt % 32]  = m_fl[m_fh % 128];
        m_old[m_rt % 32]  = m_frat[d[k]];
        m_frat[d[k]] = m_fl[m_fh % 128];
        m_fh++; m_rt++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    vld = '0; dst = '0; s1 = '0; s2 = '0; req = '0; flush = 1'b0;
    for (int i = 0; i < 8; i++) begin m_frat[i] = i; m_rrat[i] = i; end
    for (int i = 0; i < 128; i++) m_fl[i] = (i < 120) ? i + 8 : 0;
    m_fh = 0; m_ft = 120; m_fr = 0; m_rh = 0; m_rt = 0;
    first = 1; post_flush = 0; post_ret = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R1 reset mapping, R3/R4 same-group bypass on arch 1
    step(3'b111, {3'd2, 3'd1, 3'd1}, {3'd1, 3'd1, 3'd0}, {3'd2, 3'd4, 3'd7}, 0, 0);
    // R6 fill reorder buffer to its limit
    for (int i = 0; i < 10; i++) step(3'b111, {3'd5, 3'd6, 3'd7}, {3'd7, 3'd6, 3'd5}, '0, 0, 0);
    step(3'b011, {3'd0, 3'd3, 3'd4}, {3'd4, 3'd4, 3'd3}, '0, 0, 0);
    step(3'b001, {3'd0, 3'd0, 3'd2}, '0, '0, 0, 0);
    step(3'b111, {3'd1, 3'd2, 3'd3}, '0, '0, 3, 0);
    step(3'b101, {3'd4, 3'd0, 3'd4}, {3'd4, 3'd0, 3'd4}, '0, 2, 0);
    // R9 flush with requests present
    step(3'b111, {3'd1, 3'd2, 3'd3}, '0, '0, 3, 1);
    step(3'b111, {3'd0, 3'd1, 3'd2}, {3'd5, 3'd4, 3'd3}, {3'd2, 3'd1, 3'd0}, 3, 0);
    step(3'b110, {3'd3, 3'd3, 3'd3}, {3'd3, 3'd3, 3'd3}, '0, 3, 0);
    for (int i = 0; i < 3000; i++)
      step(3'($urandom), {3'($urandom), 3'($urandom), 3'($urandom)},
           {3'($urandom), 3'($urandom), 3'($urandom)},
           {3'($urandom), 3'($urandom), 3'($urandom)},
           int'($urandom % 4), ($urandom % 40) == 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule